// File: doc/BRIEF.md
# Programmable Width One-Shot Generator

This block is a clocked one-shot. It turns a rising edge on a trigger input into exactly one output pulse. The pulse width, counted in clock cycles, comes from a 3-bit width code: a base width plus one step for each unit of the code. The base width, the step size, the start delay and the post-pulse lockout are parameters. The outputs come as a complementary pair, one true and one inverted.

The trigger is asynchronous to the clock. It passes through a two-flop synchronizer before edge detection. After a detected edge the block waits a fixed start delay, then drives the pulse. After the pulse it holds a recovery lockout, and only then accepts another edge. Edges that arrive during the delay, the pulse or the lockout are discarded, and they are not queued. The width code is not captured when the trigger arrives. It is compared against the running count on every cycle, so the code must stay stable for the whole pulse. An active-high asynchronous reset ends any activity at once and leaves the block idle.

Top module: `oneshot_pw_gen`

## Requirements
- R1: With a stable code A on `sel_i` (unsigned, 3 bits), `pulse_o` stays high for exactly BASE_W + STEP_W*A consecutive clock cycles. The width grows strictly with A.
- R2: Only a low-to-high transition of `fire_i` starts a pulse. Holding `fire_i` high after a pulse produces no further pulse.
- R3: `pulse_o` rises on the clock edge that comes 3 + START_DLY edges after the first edge that samples `fire_i` high. Two edges go to synchronization, one to edge registration, and the rest to the start delay.
- R4: A trigger edge detected while the pulse is high neither lengthens the pulse nor starts a later one.
- R5: For RECOV_CYC clock cycles after the pulse ends, detected trigger edges are ignored. An edge detected on the first cycle after the lockout is accepted.
- R6: While `rst_i` is high, `pulse_o` is 0 and `pulse_n_o` is 1, and this takes effect at once, even in the middle of a pulse. After release, the block accepts the next trigger edge normally.
- R7: `sel_i` is read live. If the code changes during a pulse, the pulse ends once its length reaches the width of the new code, or on the next cycle if that width has already been passed.
- R8: `pulse_n_o` is always the complement of `pulse_o`.
- R9: BASE_W and STEP_W must be at least 1, and this is checked at elaboration. Code 0 therefore gives a pulse of BASE_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| fire_i | input | 1 | Asynchronous trigger, rising edge active |
| sel_i | input | ADDR_W | Width code, read on every cycle |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Inverted pulse output |

## Verification
A wrong sequencer state shows up at the ports within one pulse. A lost or early delay moves the rising edge of `pulse_o` away from the fixed latency. A wrong count or compare makes the measured width differ from BASE_W + STEP_W*A for some code. A missing lockout produces an extra pulse when an edge lands just inside the recovery window. The bench places second edges on both sides of the lockout boundary, changes the code in the middle of a pulse in both directions, and resets during a pulse, so each of these faults changes a count that the bench measures.

// File: rtl/oneshot_pw_pkg.sv
package oneshot_pw_pkg;

   typedef enum logic [1:0] {
      OS_IDLE    = 2'd0,
      OS_DELAY   = 2'd1,
      OS_PULSE   = 2'd2,
      OS_RECOVER = 2'd3
   } os_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/oneshot_edge_det.sv
module oneshot_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic din_i,
   output logic rise_o
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q[0] <= 1'b0;
            else       chain_q[0] <= din_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q[i] <= 1'b0;
            else       chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) last_q <= 1'b0;
      else       last_q <= chain_q[SYNC_STAGES-1];
   end

   assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/oneshot_width_calc.sv
module oneshot_width_calc
   import oneshot_pw_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int BASE_W = 3,
   parameter int STEP_W = 2,
   parameter int CNT_W  = 5
) (
   input  logic [ADDR_W-1:0] sel_i,
   output logic [CNT_W-1:0]  width_o
);
   localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_W);

   if (is_pow2(STEP_W)) begin : g_shift
      localparam int SHIFT = $clog2(STEP_W);
      assign width_o = BASE_V + (CNT_W'(sel_i) << SHIFT);
   end else begin : g_mult
      localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP_W);
      assign width_o = BASE_V + STEP_V * CNT_W'(sel_i);
   end
endmodule

// File: rtl/oneshot_seq.sv
module oneshot_seq
   import oneshot_pw_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int START_DLY = 2,
   parameter int RECOV_CYC = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] width_i,
   output os_state_e        state_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             active_o
);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(START_DLY - 1);
   localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECOV_CYC - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   os_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         state_q <= OS_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            OS_IDLE: begin
               cnt_q <= '0;
               if (rise_i) state_q <= OS_DELAY;
            end
            OS_DELAY: begin
               if (cnt_q >= DLY_LAST) begin
                  state_q <= OS_PULSE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            OS_PULSE: begin
               if (cnt_q >= width_i - ONE) begin
                  state_q <= OS_RECOVER;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: begin
               if (cnt_q >= REC_LAST) begin
                  state_q <= OS_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
         endcase
      end
   end

   assign state_o  = state_q;
   assign cnt_o    = cnt_q;
   assign active_o = (state_q == OS_PULSE);
endmodule

// File: rtl/oneshot_pw_gen.sv
module oneshot_pw_gen
   import oneshot_pw_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int BASE_W      = 3,
   parameter int STEP_W      = 2,
   parameter int START_DLY   = 2,
   parameter int RECOV_CYC   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              fire_i,
   input  logic [ADDR_W-1:0] sel_i,
   output logic              pulse_o,
   output logic              pulse_n_o
);
   localparam int MAX_W   = BASE_W + STEP_W * ((1 << ADDR_W) - 1);
   localparam int MAX_CNT = max3(MAX_W, START_DLY, RECOV_CYC);
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   // R9: elaboration-time parameter checks
   if (BASE_W < 1) begin : g_bad_base
      $error("BASE_W must be at least 1");
   end
   if (STEP_W < 1) begin : g_bad_step
      $error("STEP_W must be at least 1");
   end
   if (START_DLY < 1) begin : g_bad_dly
      $error("START_DLY must be at least 1");
   end
   if (RECOV_CYC < 1) begin : g_bad_rec
      $error("RECOV_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             rise_w;
   logic [CNT_W-1:0] width_w;
   logic [CNT_W-1:0] cnt_w;
   os_state_e        state_w;
   logic             active_w;

   oneshot_edge_det #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .din_i (fire_i),
      .rise_o(rise_w)
   );

   oneshot_width_calc #(
      .ADDR_W(ADDR_W),
      .BASE_W(BASE_W),
      .STEP_W(STEP_W),
      .CNT_W (CNT_W)
   ) u_width (
      .sel_i  (sel_i),
      .width_o(width_w)
   );

   oneshot_seq #(
      .CNT_W    (CNT_W),
      .START_DLY(START_DLY),
      .RECOV_CYC(RECOV_CYC)
   ) u_seq (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .rise_i  (rise_w),
      .width_i (width_w),
      .state_o (state_w),
      .cnt_o   (cnt_w),
      .active_o(active_w)
   );

   assign pulse_o   = active_w;
   assign pulse_n_o = ~active_w;
endmodule

// File: rtl/oneshot_pw_chk.sv
module oneshot_pw_chk
   import oneshot_pw_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int START_DLY = 2,
   parameter int RECOV_CYC = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             rise,
   input os_state_e        state,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] width,
   input logic             out_t,
   input logic             out_n
);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(START_DLY - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   // R6: reset forces the output pair
   always @(posedge clk) begin
      if (rst) begin
         p_rst_forces_r6: assert (!out_t && out_n);
      end
   end

   p_compl_r8: assert property (@(posedge clk) disable iff (rst)
      out_n == !out_t);

   p_idle_needs_edge_r2: assert property (@(posedge clk) disable iff (rst)
      (state == OS_IDLE && !rise) |=> (state == OS_IDLE));

   p_rise_after_delay_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(out_t) |-> ($past(state) == OS_DELAY && $past(cnt) == DLY_LAST));

   p_fall_at_width_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(out_t) |-> ($past(state) == OS_PULSE && $past(cnt) >= $past(width) - ONE));

   p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
      (state == OS_PULSE && rise) |=> (state != OS_DELAY));

   p_lockout_after_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(out_t) |-> (state == OS_RECOVER));

   p_lockout_ignore_r5: assert property (@(posedge clk) disable iff (rst)
      (state == OS_RECOVER && rise) |=> (state != OS_DELAY));
endmodule

bind oneshot_pw_gen oneshot_pw_chk #(
   .CNT_W    (CNT_W),
   .START_DLY(START_DLY),
   .RECOV_CYC(RECOV_CYC)
) u_chk (
   .clk  (clk_i),
   .rst  (rst_i),
   .rise (rise_w),
   .state(state_w),
   .cnt  (cnt_w),
   .width(width_w),
   .out_t(pulse_o),
   .out_n(pulse_n_o)
);

// File: tb/oneshot_pw_gen_tb_top.sv
module oneshot_pw_gen_tb_top;
   localparam int ADDR_W = 3;
   localparam int BASE_W = 3;
   localparam int STEP_W = 2;
   localparam int DLY    = 2;
   localparam int RECOV  = 4;
   localparam int LAT    = 3 + DLY;   // sample index of first high output
   localparam int NSAMP  = 70;

   logic              clk_i = 1'b0;
   logic              rst_i;
   logic              fire_i;
   logic [ADDR_W-1:0] sel_i;
   logic              pulse_o;
   logic              pulse_n_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk_i = ~clk_i;

   oneshot_pw_gen #(
      .ADDR_W(ADDR_W), .BASE_W(BASE_W), .STEP_W(STEP_W),
      .START_DLY(DLY), .RECOV_CYC(RECOV), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i(clk_i), .rst_i(rst_i), .fire_i(fire_i), .sel_i(sel_i),
      .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
   );

   function automatic int exp_w(input int a);
      return BASE_W + STEP_W * a;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Raise fire at a negedge (index 0), then sample NSAMP negedges.
   task automatic pulse_run(input int sel0, input int chg_at, input int sel1,
                            input int refire_at, input bit hold,
                            output int first, output int hi, output int rises,
                            output int compl_bad);
      int prev;
      first = -1; hi = 0; rises = 0; compl_bad = 0; prev = 0;
      @(negedge clk_i);
      sel_i  = ADDR_W'(sel0);
      fire_i = 1'b1;
      for (int i = 1; i <= NSAMP; i++) begin
         @(negedge clk_i);
         if (pulse_n_o == pulse_o) compl_bad++;
         if (pulse_o) begin
            hi++;
            if (first < 0) first = i;
            if (prev == 0) rises++;
         end
         prev = int'(pulse_o);
         if (i == 3 && !hold) fire_i = 1'b0;
         if (i == refire_at) fire_i = 1'b1;
         if (i == refire_at + 3 && !hold) fire_i = 1'b0;
         if (i == chg_at) sel_i = ADDR_W'(sel1);
      end
      fire_i = 1'b0;
      repeat (4) @(negedge clk_i);
   endtask

   task automatic t_reset_state;
      chk("R6 reset pulse_o", int'(pulse_o), 0);
      chk("R6 reset pulse_n_o", int'(pulse_n_o), 1);
   endtask

   task automatic t_sweep;
      int f, h, r, c;
      for (int a = 0; a < 8; a++) begin
         pulse_run(a, -1, 0, -1, 0, f, h, r, c);
         chk($sformatf("R3 latency code %0d", a), f, LAT);
         chk($sformatf("R1 width code %0d", a), h, exp_w(a));
         chk("R8 complement", c, 0);
         if (a == 0) chk("R9 code 0 width", h, BASE_W);
      end
   endtask

   task automatic t_level;
      int f, h, r, c;
      pulse_run(1, -1, 0, -1, 1, f, h, r, c);
      chk("R2 held level single pulse", r, 1);
      chk("R2 held level width", h, exp_w(1));
   endtask

   task automatic t_busy;
      int f, h, r, c;
      // code 7: high at samples 5..21; second edge raised at 8, seen during pulse
      pulse_run(7, -1, 0, 8, 0, f, h, r, c);
      chk("R4 retrigger in pulse pulses", r, 1);
      chk("R4 retrigger in pulse width", h, exp_w(7));
   endtask

   task automatic t_recover;
      int f, h, r, c;
      // code 0: high samples 5..7, lockout clocked at edges 9..12, idle at 13
      pulse_run(0, -1, 0, 7, 0, f, h, r, c);
      chk("R5 edge mid lockout ignored", r, 1);
      pulse_run(0, -1, 0, 9, 0, f, h, r, c);
      chk("R5 edge on last lockout cycle ignored", r, 1);
      pulse_run(0, -1, 0, 10, 0, f, h, r, c);
      chk("R5 edge right after lockout accepted", r, 2);
      chk("R5 two pulse total width", h, 2 * exp_w(0));
   endtask

   task automatic t_live_sel;
      int f, h, r, c;
      pulse_run(1, 6, 5, -1, 0, f, h, r, c);
      chk("R7 code raised mid pulse", h, exp_w(5));
      pulse_run(7, 6, 0, -1, 0, f, h, r, c);
      chk("R7 code lowered mid pulse", h, 3);
   endtask

   task automatic t_reset_mid;
      int f, h, r, c;
      @(negedge clk_i);
      sel_i  = 3'd7;
      fire_i = 1'b1;
      repeat (3) @(negedge clk_i);
      fire_i = 1'b0;
      repeat (LAT + 2 - 3) @(negedge clk_i);
      chk("R6 pulse high before reset", int'(pulse_o), 1);
      rst_i = 1'b1;
      #1;
      chk("R6 mid pulse reset pulse_o", int'(pulse_o), 0);
      chk("R6 mid pulse reset pulse_n_o", int'(pulse_n_o), 1);
      @(negedge clk_i);
      rst_i = 1'b0;
      repeat (2) @(negedge clk_i);
      chk("R6 stays low after reset", int'(pulse_o), 0);
      pulse_run(2, -1, 0, -1, 0, f, h, r, c);
      chk("R6 ready after reset latency", f, LAT);
      chk("R6 ready after reset width", h, exp_w(2));
   endtask

   initial begin
      rst_i  = 1'b1;
      fire_i = 1'b0;
      sel_i  = '0;
      repeat (4) @(negedge clk_i);
      t_reset_state();
      rst_i = 1'b0;
      repeat (2) @(negedge clk_i);
      t_sweep();
      t_level();
      t_busy();
      t_recover();
      t_live_sel();
      t_reset_mid();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule